// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock domains of a small 8-bit microcontroller run at any moment. It follows three power situations: normal operation, a light sleep entered by a wait strobe from the instruction decoder, and a deep sleep entered by a stop strobe. In light sleep the processor clock is off, and each peripheral clock follows its own enable bit. The free-running timer is parked only when interrupts are masked and the watchdog is off. While the sleep lasts, the bus is told to keep reading the location that holds the stacked status byte. In deep sleep every clock, the oscillator included, is off.

Leaving light sleep needs an interrupt that is not masked. Leaving deep sleep needs a low level on one of the two external interrupt pins or an edge interrupt that is already latched. After deep sleep the oscillator is switched on first. A restart counter then has to run out before the processor and the peripherals get their clocks back. The counter has a long default delay and a short one chosen by an option input. The processor is told that it is awake by a one-cycle wake pulse.

The stop strobe is honoured only when the stop-disable condition-code bit is clear; otherwise it does nothing. The reset is synchronous and active high, and it returns the block to normal operation from any state.

Top module: `lpm_sequencer`

## Requirements
- R1: A cycle with `rst` high puts the block in RUN at the next edge: all seven clock enables 1, `wake` 0, `bus_rd` 0, `bus_addr` 0 and the restart counter cleared. A restart in progress is abandoned.
- R2: In RUN, `wait_req` (when no honoured stop is requested) moves to WAIT at the next edge. In WAIT, `cpu_clk_en` is 0, `osc_en` is 1, `bus_rd` is 1 and `bus_addr` equals `stack_addr`. `wait_req` and `stop_req` have no effect in WAIT.
- R3: In WAIT, `tmr_clk_en` is 0 only when `ccr_imask`=1 and `wdog_off`=1. Otherwise it is 1.
- R4: In WAIT, `adc_clk_en`, `spi_clk_en`, `sci_tx_clk_en` and `sci_rx_clk_en` equal `adc_pwr_en`, `spi_en`, `sci_tx_en` and `sci_rx_en` respectively.
- R5: WAIT returns to RUN at the next edge when `xirq_n`=0 (never masked). It also returns when `ccr_imask`=0 and any of these holds: `irq_n`=0, `irq_edge_pend`=1, or any bit of `int_req`=1. With `ccr_imask`=1 and `xirq_n`=1, the block stays in WAIT.
- R6: In RUN, `stop_req` with `ccr_sdis`=0 moves to STOP at the next edge, and this takes priority over a simultaneous `wait_req`. In STOP, all seven enables and `bus_rd` are 0.
- R7: `stop_req` with `ccr_sdis`=1 is a no-op: the block stays in RUN with all enables 1.
- R8: STOP is left when `irq_n`=0, `xirq_n`=0 or `irq_edge_pend`=1, whatever the value of `ccr_imask`. `int_req` alone does not end STOP.
- R9: After STOP, the block spends exactly D cycles with only `osc_en`=1 and then enters RUN. D is SHORT_DLY (default 4) if `fast_restart` was 1 at the exit edge, and LONG_DLY (default 4064) otherwise.
- R10: `wake` is 1 for exactly one cycle: the first RUN cycle after WAIT or after the restart delay. It is never 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | Decoded wait-instruction strobe |
| stop_req | input | 1 | Decoded stop-instruction strobe |
| ccr_imask | input | 1 | Interrupt-mask condition-code bit |
| ccr_sdis | input | 1 | Stop-disable condition-code bit |
| wdog_off | input | 1 | Watchdog-disabled configuration bit |
| adc_pwr_en | input | 1 | Converter power-up bit |
| spi_en | input | 1 | SPI enable bit |
| sci_tx_en | input | 1 | Serial transmitter enable bit |
| sci_rx_en | input | 1 | Serial receiver enable bit |
| irq_n | input | 1 | Maskable external interrupt pin, active low |
| xirq_n | input | 1 | Non-maskable external interrupt pin, active low |
| irq_edge_pend | input | 1 | Latched edge-triggered interrupt pending |
| int_req | input | NUM_INT | Internal interrupt requests |
| fast_restart | input | 1 | Selects the short restart delay |
| stack_addr | input | ADDR_W | Address of the stacked status byte |
| osc_en | output | 1 | Crystal oscillator enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| tmr_clk_en | output | 1 | Free-running timer clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| spi_clk_en | output | 1 | SPI clock enable |
| sci_tx_clk_en | output | 1 | Serial transmitter clock enable |
| sci_rx_clk_en | output | 1 | Serial receiver clock enable |
| wake | output | 1 | One-cycle wake pulse to the processor |
| bus_rd | output | 1 | Repeated read request during WAIT |
| bus_addr | output | ADDR_W | Read address during WAIT, 0 otherwise |

## Verification
The hardest case to reach is the end of the long restart delay, in particular a reset that lands part-way through it. Only a deep-sleep exit reaches that delay, and the delay lasts thousands of cycles. The stimulus therefore enters STOP, releases it with the non-maskable pin, and runs the full long delay once. It then enters STOP again, releases it with a latched edge interrupt, and pulses reset in the middle of the delay. A reference model that counts the delay on its own is compared with every output on every clock, so an off-by-one at either end of the delay shows up.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_WAIT    = 2'd1,
        PM_STOP    = 2'd2,
        PM_RESTART = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic osc;
        logic cpu;
        logic tmr;
        logic adc;
        logic spi;
        logic sci_tx;
        logic sci_rx;
    } clk_en_s;

    typedef struct packed {
        logic adc;
        logic spi;
        logic sci_tx;
        logic sci_rx;
    } periph_cfg_s;

    localparam clk_en_s CLK_ALL_ON  = '{default: 1'b1};
    localparam clk_en_s CLK_ALL_OFF = '{default: 1'b0};

    // timer may be parked only when nothing can need it
    function automatic logic timer_parked(input logic imask, input logic wdog_off);
        return imask & wdog_off;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NUM_INT = 4
) (
    input  logic               irq_n,
    input  logic               xirq_n,
    input  logic               irq_edge_pend,
    input  logic [NUM_INT-1:0] int_req,
    input  logic               imask,
    output logic               wait_exit,
    output logic               stop_exit
);
    logic maskable_any;
    logic internal_any;

    generate
        if (NUM_INT > 0) begin : g_int
            assign internal_any = |int_req;
        end else begin : g_noint
            assign internal_any = 1'b0;
        end
    endgenerate

    assign maskable_any = ~irq_n | irq_edge_pend | internal_any;

    always_comb begin
        wait_exit = ~xirq_n | (maskable_any & ~imask);
        stop_exit = ~irq_n | ~xirq_n | irq_edge_pend;
    end
endmodule

// File: rtl/lpm_restart_timer.sv
module lpm_restart_timer #(
    parameter int unsigned LONG_DLY  = 4064,
    parameter int unsigned SHORT_DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic short_sel,
    output logic done
);
    import lpm_pkg::*;

    localparam int unsigned MAX_DLY = max_u(LONG_DLY, SHORT_DLY);
    localparam int CNT_W = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY);
    localparam logic [CNT_W-1:0] LONG_RELOAD  = CNT_W'(LONG_DLY - 1);
    localparam logic [CNT_W-1:0] SHORT_RELOAD = CNT_W'(SHORT_DLY - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= short_sel ? SHORT_RELOAD : LONG_RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_clock_decode.sv
module lpm_clock_decode
    import lpm_pkg::*;
(
    input  pm_state_e   state,
    input  logic        imask,
    input  logic        wdog_off,
    input  periph_cfg_s cfg,
    output clk_en_s     en,
    output logic        bus_rd
);
    always_comb begin
        en     = CLK_ALL_OFF;
        bus_rd = 1'b0;
        unique case (state)
            PM_RUN: begin
                en = CLK_ALL_ON;
            end
            PM_WAIT: begin
                en.osc    = 1'b1;
                en.cpu    = 1'b0;
                en.tmr    = ~timer_parked(imask, wdog_off);
                en.adc    = cfg.adc;
                en.spi    = cfg.spi;
                en.sci_tx = cfg.sci_tx;
                en.sci_rx = cfg.sci_rx;
                bus_rd    = 1'b1;
            end
            PM_RESTART: begin
                en.osc = 1'b1;
            end
            default: begin
                en = CLK_ALL_OFF;
            end
        endcase
    end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer #(
    parameter int          NUM_INT   = 4,
    parameter int          ADDR_W    = 16,
    parameter int unsigned LONG_DLY  = 4064,
    parameter int unsigned SHORT_DLY = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wait_req,
    input  logic               stop_req,
    input  logic               ccr_imask,
    input  logic               ccr_sdis,
    input  logic               wdog_off,
    input  logic               adc_pwr_en,
    input  logic               spi_en,
    input  logic               sci_tx_en,
    input  logic               sci_rx_en,
    input  logic               irq_n,
    input  logic               xirq_n,
    input  logic               irq_edge_pend,
    input  logic [NUM_INT-1:0] int_req,
    input  logic               fast_restart,
    input  logic [ADDR_W-1:0]  stack_addr,
    output logic               osc_en,
    output logic               cpu_clk_en,
    output logic               tmr_clk_en,
    output logic               adc_clk_en,
    output logic               spi_clk_en,
    output logic               sci_tx_clk_en,
    output logic               sci_rx_clk_en,
    output logic               wake,
    output logic               bus_rd,
    output logic [ADDR_W-1:0]  bus_addr
);
    import lpm_pkg::*;

    pm_state_e   state_q, state_d;
    logic        wake_q, wake_d;
    logic        wait_exit, stop_exit;
    logic        restart_load, restart_done;
    logic        stop_ok;
    periph_cfg_s cfg;
    clk_en_s     en;

    lpm_wake_qual #(.NUM_INT(NUM_INT)) u_qual (
        .irq_n         (irq_n),
        .xirq_n        (xirq_n),
        .irq_edge_pend (irq_edge_pend),
        .int_req       (int_req),
        .imask         (ccr_imask),
        .wait_exit     (wait_exit),
        .stop_exit     (stop_exit)
    );

    lpm_restart_timer #(.LONG_DLY(LONG_DLY), .SHORT_DLY(SHORT_DLY)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (restart_load),
        .short_sel (fast_restart),
        .done      (restart_done)
    );

    assign stop_ok      = stop_req & ~ccr_sdis;
    assign restart_load = (state_q == PM_STOP) & stop_exit;

    always_comb begin
        state_d = state_q;
        wake_d  = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                if (stop_ok)       state_d = PM_STOP;
                else if (wait_req) state_d = PM_WAIT;
            end
            PM_WAIT: begin
                if (wait_exit) begin
                    state_d = PM_RUN;
                    wake_d  = 1'b1;
                end
            end
            PM_STOP: begin
                if (stop_exit) state_d = PM_RESTART;
            end
            PM_RESTART: begin
                if (restart_done) begin
                    state_d = PM_RUN;
                    wake_d  = 1'b1;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= wake_d;
        end
    end

    assign cfg = '{adc: adc_pwr_en, spi: spi_en, sci_tx: sci_tx_en, sci_rx: sci_rx_en};

    lpm_clock_decode u_dec (
        .state    (state_q),
        .imask    (ccr_imask),
        .wdog_off (wdog_off),
        .cfg      (cfg),
        .en       (en),
        .bus_rd   (bus_rd)
    );

    assign osc_en        = en.osc;
    assign cpu_clk_en    = en.cpu;
    assign tmr_clk_en    = en.tmr;
    assign adc_clk_en    = en.adc;
    assign spi_clk_en    = en.spi;
    assign sci_tx_clk_en = en.sci_tx;
    assign sci_rx_clk_en = en.sci_rx;
    assign wake          = wake_q;
    assign bus_addr      = bus_rd ? stack_addr : '0;
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk
    import lpm_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input pm_state_e state,
    input logic      wait_req,
    input logic      stop_req,
    input logic      ccr_imask,
    input logic      ccr_sdis,
    input logic      wdog_off,
    input logic      irq_n,
    input logic      xirq_n,
    input logic      osc_en,
    input logic      cpu_clk_en,
    input logic      tmr_clk_en,
    input logic      wake,
    input logic      bus_rd
);
    AST_RESET_RUN: assert property (@(posedge clk)
        rst |=> (state == PM_RUN && osc_en && cpu_clk_en && tmr_clk_en && !wake && !bus_rd)); // R1

    AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && wait_req && !(stop_req && !ccr_sdis)) |=> (!cpu_clk_en && osc_en && bus_rd)); // R2

    AST_TIMER_PARK: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WAIT && ccr_imask && wdog_off) |-> !tmr_clk_en); // R3

    AST_XIRQ_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WAIT && !xirq_n) |=> (wake && state == PM_RUN)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == PM_WAIT && ccr_imask && xirq_n) |=> (state == PM_WAIT)); // R5

    AST_STOP_DARK: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && stop_req && !ccr_sdis) |=> (!osc_en && !cpu_clk_en && !tmr_clk_en && !bus_rd)); // R6

    AST_STOP_NOP: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RUN && stop_req && ccr_sdis && !wait_req) |=> (state == PM_RUN && cpu_clk_en)); // R7

    AST_STOP_PIN_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == PM_STOP && !irq_n) |=> (osc_en && !cpu_clk_en)); // R8

    AST_RESTART_OSC: assert property (@(posedge clk) disable iff (rst)
        (state == PM_RESTART) |-> (osc_en && !cpu_clk_en && !bus_rd)); // R9

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake |=> !wake); // R10

    AST_WAKE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        wake |-> (state == PM_RUN && cpu_clk_en)); // R10
endmodule

bind lpm_sequencer lpm_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state_q),
    .wait_req   (wait_req),
    .stop_req   (stop_req),
    .ccr_imask  (ccr_imask),
    .ccr_sdis   (ccr_sdis),
    .wdog_off   (wdog_off),
    .irq_n      (irq_n),
    .xirq_n     (xirq_n),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .tmr_clk_en (tmr_clk_en),
    .wake       (wake),
    .bus_rd     (bus_rd)
);

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
    localparam int NI = 4;
    localparam int AW = 16;
    localparam int LD = 4064;
    localparam int SD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wait_req = 0, stop_req = 0, ccr_imask = 0, ccr_sdis = 0, wdog_off = 0;
    logic adc_pwr_en = 0, spi_en = 0, sci_tx_en = 0, sci_rx_en = 0;
    logic irq_n = 1, xirq_n = 1, irq_edge_pend = 0, fast_restart = 0;
    logic [NI-1:0] int_req = '0;
    logic [AW-1:0] stack_addr = 16'h01F7;
    logic osc_en, cpu_clk_en, tmr_clk_en, adc_clk_en, spi_clk_en, sci_tx_clk_en, sci_rx_clk_en;
    logic wake, bus_rd;
    logic [AW-1:0] bus_addr;

    int tests = 0, fails = 0;
    bit finished = 0, started = 0;

    always #4 clk = ~clk;

    lpm_sequencer #(.NUM_INT(NI), .ADDR_W(AW), .LONG_DLY(LD), .SHORT_DLY(SD)) uut (.*);

    // reference model: 0 run, 1 wait, 2 stop, 3 restart
    int m_st = 0, m_left = 0;
    bit m_wake = 0;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_st = 0; m_left = 0; m_wake = 0;
        end else begin
            m_wake = 0;
            case (m_st)
                0: if (stop_req && !ccr_sdis) m_st = 2; else if (wait_req) m_st = 1;
                1: if (!xirq_n || (!ccr_imask && (!irq_n || irq_edge_pend || int_req != 0))) begin
                       m_st = 0; m_wake = 1;
                   end
                2: if (!irq_n || !xirq_n || irq_edge_pend) begin
                       m_st = 3; m_left = fast_restart ? SD : LD;
                   end
                default: begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin m_st = 0; m_wake = 1; end
                end
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_of();
        if (m_wake) return "R10";
        case (m_st)
            0: return "R1/R7";
            1: return "R2/R3/R4";
            2: return "R6";
            default: return "R9";
        endcase
    endfunction

    // every-cycle comparison against the model
    always begin
        @(negedge clk);
        #2;
        if (started && !finished) begin
            logic [6:0] e;
            logic exp_rd;
            case (m_st)
                0: e = 7'h7F;
                1: e = {1'b1, 1'b0, !(ccr_imask && wdog_off), adc_pwr_en, spi_en, sci_tx_en, sci_rx_en};
                2: e = 7'h00;
                default: e = 7'h40;
            endcase
            exp_rd = (m_st == 1);
            chk(tag_of(), {osc_en, cpu_clk_en, tmr_clk_en, adc_clk_en, spi_clk_en, sci_tx_clk_en, sci_rx_clk_en}, e);
            chk(tag_of(), {wake, bus_rd, bus_addr}, {m_wake, exp_rd, exp_rd ? stack_addr : 16'h0});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1200000;
        tests++; fails++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        summary();
    end

    initial begin
        int n;
        tick(3);
        rst = 0;
        #3 chk("R1", {osc_en, cpu_clk_en, wake, bus_rd}, 4'b1100);

        // wait, peripherals mixed, woken by internal request
        tick(1);
        adc_pwr_en = 1; spi_en = 0; sci_tx_en = 1; sci_rx_en = 0; wait_req = 1;
        tick(1); wait_req = 0;
        #3 chk("R2", {cpu_clk_en, osc_en, bus_rd}, 3'b011);
        chk("R2", bus_addr, stack_addr);
        chk("R4", {adc_clk_en, spi_clk_en, sci_tx_clk_en, sci_rx_clk_en}, 4'b1010);
        chk("R3", tmr_clk_en, 1'b1);
        stack_addr = 16'h00A3; stop_req = 1;
        tick(1); stop_req = 0;
        #3 chk("R2", {bus_rd, bus_addr}, {1'b1, 16'h00A3});
        int_req = 4'b0100;
        tick(1); int_req = 0;
        #3 chk("R5", {wake, cpu_clk_en}, 2'b11);
        tick(1);
        #3 chk("R10", wake, 1'b0);

        // masked wait: timer parked, maskable sources ignored, xirq wakes
        ccr_imask = 1; wdog_off = 1; wait_req = 1;
        tick(1); wait_req = 0;
        #3 chk("R3", tmr_clk_en, 1'b0);
        int_req = 4'b1001; irq_n = 0; irq_edge_pend = 1;
        tick(2);
        #3 chk("R5", {cpu_clk_en, bus_rd}, 2'b01);
        int_req = 0; irq_n = 1; irq_edge_pend = 0; xirq_n = 0;
        tick(1); xirq_n = 1;
        #3 chk("R5", wake, 1'b1);

        // mask set, watchdog on: timer keeps running; edge pend with mask clear wakes
        wdog_off = 0; wait_req = 1;
        tick(1); wait_req = 0;
        #3 chk("R3", tmr_clk_en, 1'b1);
        ccr_imask = 0; irq_edge_pend = 1;
        tick(1); irq_edge_pend = 0;
        #3 chk("R5", wake, 1'b1);
        ccr_imask = 1; wdog_off = 1; wait_req = 1;
        tick(1); wait_req = 0;
        ccr_imask = 0; irq_n = 0;
        tick(1); irq_n = 1;
        #3 chk("R5", wake, 1'b1);

        // stop disabled: no-op
        ccr_sdis = 1; stop_req = 1;
        tick(1); stop_req = 0;
        #3 chk("R7", {osc_en, cpu_clk_en, bus_rd}, 3'b110);
        tick(2);

        // stop with wait together; stop wins; int_req ignored; irq pin exits, short delay
        ccr_sdis = 0; ccr_imask = 1; stop_req = 1; wait_req = 1;
        tick(1); stop_req = 0; wait_req = 0;
        #3 chk("R6", {osc_en, cpu_clk_en, tmr_clk_en, bus_rd}, 4'b0000);
        int_req = 4'b1111;
        tick(3);
        #3 chk("R8", osc_en, 1'b0);
        int_req = 0; irq_n = 0; fast_restart = 1;
        n = 0;
        do begin tick(1); irq_n = 1; fast_restart = 0; n++; end while (!wake && n < 10000);
        chk("R9", n, SD + 1);

        // stop, xirq exit, long delay
        stop_req = 1;
        tick(1); stop_req = 0;
        tick(2);
        xirq_n = 0;
        tick(1); xirq_n = 1;
        #3 chk("R9", {osc_en, cpu_clk_en}, 2'b10);
        n = 1;
        do begin tick(1); n++; end while (!wake && n < 10000);
        chk("R9", n, LD + 1);
        chk("R10", cpu_clk_en, 1'b1);

        // stop, edge pend exit, reset mid-restart
        stop_req = 1;
        tick(1); stop_req = 0;
        irq_edge_pend = 1;
        tick(1); irq_edge_pend = 0;
        tick(100);
        rst = 1;
        tick(1); rst = 0;
        #3 chk("R1", {osc_en, cpu_clk_en, wake}, 3'b110);
        tick(LD + 20);
        #3 chk("R1", wake, 1'b0);

        tick(2);
        summary();
    end
endmodule